// File: doc/BRIEF.md
# Serial Trim-Converter Update Sender

This block sits on the host side of a three-wire link to an octal trim converter. A caller presents a 3-bit channel number and an 8-bit level, then pulses a start strobe for one clock. The block then moves the two fields out one bit at a time: it pulls the active-low select line down, walks through the eleven bits with the channel number ahead of the level and the most significant bit of each field first, and releases the select line. The receiver commits the new level when select goes high.

The serial clock rests high. For each bit the block places the bit on the data line, drops the serial clock, and raises it again. The receiver samples on that rising edge. Each half of a bit period lasts `HALF_DIV` system clocks, so the serial rate is a parameter. The data line changes one system clock after a rising edge and never while the serial clock is low. A busy flag covers the whole frame and one idle bit period after select rises. A one-clock done pulse marks the commit. Sending several channels in a row is the caller's job.

Top module: `trim_frame_tx`

## Requirements
- R1: Out of reset and whenever busy is low, select and serial clock are both high, serial data is low, and done is low.
- R2: A start strobe seen while busy is low drives select low and busy high in the first cycle after the sampling edge.
- R3: Each frame has exactly eleven serial clock rising edges while select is low. The first three carry the channel number, most significant bit first. The next eight carry the level, most significant bit first.
- R4: Within a frame, each bit has its serial clock high for `HALF_DIV` cycles while its data is launched, then low for exactly `HALF_DIV` cycles.
- R5: Serial data does not change while the serial clock is low, and does not change in the cycle where the clock rises. So at each rising edge it has been stable for at least `HALF_DIV` cycles.
- R6: After the eleventh rising edge, select stays low for `HALF_DIV` more cycles and then rises. Counting the first cycle after the start edge as cycle 0, this happens at cycle 23·`HALF_DIV`.
- R7: Done is high for exactly one cycle, in the cycle where select returns high. There is one pulse per frame.
- R8: Busy stays high until select has been high for two half periods, a full bit period. Busy is first low at cycle 25·`HALF_DIV`.
- R9: A start strobe that arrives while busy is high is ignored. This holds both during the select-low window and during the trailing idle bit period. The frame in flight keeps its channel and level, and no second frame follows.
- R10: `HALF_DIV` must be at least 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to send a frame |
| addr_i | input | 3 | Channel number, captured on an accepted start |
| data_i | input | 8 | Level, captured on an accepted start |
| busy_o | output | 1 | High from accepted start until one bit period after select rises |
| done_o | output | 1 | One-cycle pulse when select returns high |
| cs_n_o | output | 1 | Active-low select to the converter |
| sclk_o | output | 1 | Serial clock, idles high |
| sdo_o | output | 1 | Serial data to the converter |

## Verification
The bench decodes every frame with a receiver model that samples on serial clock rising edges. It sends all 256 levels with the channel number cycling, so each bit position of both fields is seen at 0 and at 1 next to both neighbours. This separates a wrong bit order, a field swap or an off-by-one shift from a correct frame. A pass over all eight channels with alternating-bit levels isolates the address phase. Two kinds of frame carry a stray start: one arrives inside the select window and one arrives in the trailing idle period. These two cases distinguish a start guard keyed on busy from one keyed on select. On every frame the bench also checks the pulse widths, the setup window and the cycle counts for commit and busy.

// File: rtl/trim_frame_pkg.sv
package trim_frame_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HIGH,
        PH_LOW,
        PH_END,
        PH_GAP
    } phase_e;

    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic busy;
    } pins_t;

    function automatic pins_t phase_pins(phase_e ph);
        pins_t p;
        unique case (ph)
            PH_IDLE: p = '{cs_n: 1'b1, sclk: 1'b1, busy: 1'b0};
            PH_HIGH: p = '{cs_n: 1'b0, sclk: 1'b1, busy: 1'b1};
            PH_LOW:  p = '{cs_n: 1'b0, sclk: 1'b0, busy: 1'b1};
            PH_END:  p = '{cs_n: 1'b0, sclk: 1'b1, busy: 1'b1};
            PH_GAP:  p = '{cs_n: 1'b1, sclk: 1'b1, busy: 1'b1};
            default: p = '{cs_n: 1'b1, sclk: 1'b1, busy: 1'b0};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/trim_frame_tick.sv
module trim_frame_tick #(
    parameter int HALF_DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic first_o,
    output logic last_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign first_o = run_i && (cnt_q == '0);
    assign last_o  = run_i && (cnt_q == LAST);

    // R4: the half-period counter never leaves its range
    p_cnt_range_r4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R4: the count advances by one inside a half period
    p_cnt_step_r4: assert property (@(posedge clk) disable iff (rst)
        (run_i && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1) || !$past(run_i));

endmodule

// File: rtl/trim_frame_shifter.sv
module trim_frame_shifter #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         shift_i,
    output logic         msb_o
);
    logic [W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (load_i) begin
            sr_q <= load_val_i;
        end else if (shift_i) begin
            sr_q <= {sr_q[W-2:0], 1'b0};
        end
    end

    assign msb_o = sr_q[W-1];

    // R3: loading and shifting never coincide
    p_load_shift_excl_r3: assert property (@(posedge clk) disable iff (rst)
        load_i |-> !shift_i);

    // R3: a load places the frame's top bit on the line next cycle
    p_load_msb_r3: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (msb_o == $past(load_val_i[W-1])));

endmodule

// File: rtl/trim_frame_seq.sv
module trim_frame_seq
    import trim_frame_pkg::*;
#(
    parameter int NBITS = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic first_i,
    input  logic last_i,
    output logic run_o,
    output logic load_o,
    output logic shift_o,
    output logic busy_o,
    output logic cs_n_o,
    output logic sclk_o,
    output logic done_o
);
    localparam int BW = (NBITS > 1) ? $clog2(NBITS) : 1;
    localparam logic [BW-1:0] BIT_LAST = BW'(NBITS - 1);

    phase_e      ph_q, ph_d;
    logic [BW-1:0] bit_q, bit_d;
    logic        gap_q, gap_d;
    logic        done_q;
    pins_t       pins;

    always_comb begin
        ph_d  = ph_q;
        bit_d = bit_q;
        gap_d = gap_q;
        unique case (ph_q)
            PH_IDLE: begin
                if (start_i) begin
                    ph_d  = PH_HIGH;
                    bit_d = '0;
                    gap_d = 1'b0;
                end
            end
            PH_HIGH: begin
                if (last_i) ph_d = PH_LOW;
            end
            PH_LOW: begin
                if (last_i) begin
                    if (bit_q == BIT_LAST) begin
                        ph_d = PH_END;
                    end else begin
                        ph_d  = PH_HIGH;
                        bit_d = bit_q + 1'b1;
                    end
                end
            end
            PH_END: begin
                if (last_i) begin
                    ph_d  = PH_GAP;
                    gap_d = 1'b0;
                end
            end
            PH_GAP: begin
                if (last_i) begin
                    if (gap_q) ph_d = PH_IDLE;
                    else       gap_d = 1'b1;
                end
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            bit_q  <= '0;
            gap_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            ph_q   <= ph_d;
            bit_q  <= bit_d;
            gap_q  <= gap_d;
            done_q <= (ph_q == PH_END) && last_i;
        end
    end

    assign pins    = phase_pins(ph_q);
    assign cs_n_o  = pins.cs_n;
    assign sclk_o  = pins.sclk;
    assign busy_o  = pins.busy;
    assign run_o   = (ph_q != PH_IDLE);
    assign done_o  = done_q;
    assign load_o  = (ph_q == PH_IDLE) && start_i;
    assign shift_o = ((ph_q == PH_HIGH) && first_i && (bit_q != '0))
                   || ((ph_q == PH_END) && last_i);

    // R2: an accepted start opens the select window next cycle
    p_start_opens_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> (!cs_n_o && busy_o));

    // R7: done coincides with select rising
    p_done_cs_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (cs_n_o && $past(!cs_n_o)));

    // R7: done lasts one cycle
    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8: busy holds while select is high after a frame
    p_busy_after_done_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> busy_o);

endmodule

// File: rtl/trim_frame_tx.sv
module trim_frame_tx #(
    parameter int HALF_DIV = 8,
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic              sdo_o
);
    localparam int NBITS = ADDR_W + DATA_W;

    logic run, first, last, load, shift;
    logic busy, done, cs_n, sclk, sdo;

    trim_frame_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .run_i   (run),
        .first_o (first),
        .last_o  (last)
    );

    trim_frame_seq #(.NBITS(NBITS)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .first_i (first),
        .last_i  (last),
        .run_o   (run),
        .load_o  (load),
        .shift_o (shift),
        .busy_o  (busy),
        .cs_n_o  (cs_n),
        .sclk_o  (sclk),
        .done_o  (done)
    );

    trim_frame_shifter #(.W(NBITS)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load),
        .load_val_i ({addr_i, data_i}),
        .shift_i    (shift),
        .msb_o      (sdo)
    );

    assign busy_o = busy;
    assign done_o = done;
    assign cs_n_o = cs_n;
    assign sclk_o = sclk;
    assign sdo_o  = sdo;

    // R1: idle pins
    p_idle_pins_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cs_n && sclk && !sdo && !done));

    // R4: the serial clock rises only on a half-period boundary
    p_rise_aligned_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> first);

    // R5: data does not move in the cycle of a rising edge
    p_sdo_hold_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> $stable(sdo));

    // R5: data does not move while the clock is low
    p_sdo_low_r5: assert property (@(posedge clk) disable iff (rst)
        !sclk |-> $stable(sdo));

    // R9: a start during busy never reloads the frame
    p_no_reload_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && start_i) |-> !load);

    // R10: the divider supports a distinct first and last cycle
    initial begin
        p_div_min_r10: assert (HALF_DIV >= 2);
    end

endmodule

// File: tb/trim_frame_tx_bench.sv
module trim_frame_tx_bench;
    localparam int H = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [2:0] addr_i = '0;
    logic [7:0] data_i = '0;
    logic busy_o, done_o, cs_n_o, sclk_o, sdo_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    trim_frame_tx #(.HALF_DIV(H)) u_trim_frame_tx (
        .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i), .data_i(data_i),
        .busy_o(busy_o), .done_o(done_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .sdo_o(sdo_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // mode 0: clean frame; 1: stray start inside select window; 2: stray start in idle bit period
    task automatic run_frame(input logic [2:0] a, input logic [7:0] d, input int mode);
        int rises = 0, low_len = 0, stable = 0, bad_low = 0, bad_setup = 0, bad_high = 0;
        int high_len = 0, done_cnt = 0, done_at = -1, csr_at = -1, busy_fall = -1, cs_falls = 0;
        logic [10:0] got = '0;
        logic prev_sclk, prev_sdo, prev_cs;
        @(negedge clk);
        start_i = 1'b1; addr_i = a; data_i = d;
        @(negedge clk);
        start_i = 1'b0;
        prev_sclk = 1'b1; prev_sdo = sdo_o; prev_cs = 1'b1;
        for (int k = 0; k < 25 * H + 2 * H; k++) begin
            if (k == 0) check(!cs_n_o && busy_o, "R2", {cs_n_o, busy_o}, 2'b01);
            if (prev_cs && !cs_n_o) cs_falls++;
            if (!prev_cs && cs_n_o && csr_at < 0) csr_at = k;
            if (sclk_o && !prev_sclk && !cs_n_o) begin
                rises++;
                got = {got[9:0], sdo_o};
                if (low_len != H) bad_low++;
                if (sdo_o != prev_sdo || stable < H) bad_setup++;
            end
            if (!sclk_o && prev_sclk && !cs_n_o && high_len != H && rises < 11) bad_high++;
            if (!sclk_o && sdo_o != prev_sdo) bad_setup++;
            low_len  = sclk_o ? 0 : low_len + 1;
            high_len = sclk_o ? high_len + 1 : 0;
            stable   = (sdo_o == prev_sdo) ? stable + 1 : 1;
            if (done_o) begin
                done_cnt++;
                if (done_at < 0) done_at = k;
            end
            if (!busy_o && busy_fall < 0) busy_fall = k;
            prev_sclk = sclk_o; prev_sdo = sdo_o; prev_cs = cs_n_o;
            if ((mode == 1 && k == 5) || (mode == 2 && k == 23 * H + 1)) begin
                start_i = 1'b1; addr_i = ~a; data_i = ~d;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        check(rises == 11, "R3", rises, 11);
        check(got == {a, d}, "R3", got, {a, d});
        check(bad_low == 0 && bad_high == 0, "R4", bad_low + bad_high, 0);
        check(bad_setup == 0, "R5", bad_setup, 0);
        check(csr_at == 23 * H, "R6", csr_at, 23 * H);
        check(done_cnt == 1 && done_at == 23 * H, "R7", done_at, 23 * H);
        check(busy_fall == 25 * H, "R8", busy_fall, 25 * H);
        check(cs_n_o && sclk_o && !sdo_o && !busy_o, "R1", {cs_n_o, sclk_o, sdo_o, busy_o}, 4'b1100);
        if (mode != 0) check(cs_falls == 1 && done_cnt == 1, "R9", cs_falls, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cs_n_o && sclk_o && !sdo_o && !busy_o && !done_o, "R1",
              {cs_n_o, sclk_o, sdo_o, busy_o, done_o}, 5'b11000);
        rst = 1'b0;
        @(negedge clk);
        check(cs_n_o && sclk_o && !busy_o, "R1", {cs_n_o, sclk_o, busy_o}, 3'b110);
        for (int v = 0; v < 256; v++) run_frame(3'(v + (v >> 3)), 8'(v), 0);
        for (int a = 0; a < 8; a++) run_frame(3'(a), (a % 2 == 0) ? 8'hA5 : 8'h5A, 0);
        run_frame(3'b101, 8'h3C, 1);
        run_frame(3'b010, 8'hC3, 1);
        run_frame(3'b110, 8'h81, 2);
        run_frame(3'b001, 8'h7E, 2);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule